// File: doc/BRIEF.md
# Profiling Control Register Access Trap Checker

This block decides what happens to one read or write of a profiling filter control register. Each request carries the current exception level and the state that decides trapping. That state covers the halted-debug and secure-debug-disable flags, whether the monitor level exists and the hypervisor level is enabled, and the security state. It also covers a two-bit profiling-buffer owner field, the monitor's fine-grained trap enable, separate fine-grained read and write trap bits, and a coarse profiling trap bit. The block returns exactly one outcome: allow, undefined, trap to the hypervisor level, or trap to the monitor level. Trap outcomes carry a fixed exception class.

Requests enter on a valid/ready port and results leave on a valid/ready port through a single output register. A request is accepted on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output register is empty or its content is taken in the same cycle. While `rsp_ready` is low, a pending result stays unchanged and no new request is accepted. The choice of whether the halted-debug undefined check outranks the hypervisor traps is a parameter, `MON_PRIO_LOCKED`.

Top module: `sysreg_trap_checker`

## Requirements
- R1: A request at exception level 0 (`req_el` = 0) gives the outcome undefined, whatever the other inputs are.
- R2: A request at exception level 3 (`req_el` = 3) gives the outcome allow, whatever the other inputs are.
- R3: At levels 1 and 2, the outcome is undefined before any other check when `MON_PRIO_LOCKED` is 1, `dbg_halted` and `dbg_sec_dis` are 1, and the owner mismatches. The owner mismatches when `el3_present` is 1 and `pbuf_owner` is not 2'b01 with `nonsecure` = 0, or not 2'b11 with `nonsecure` = 1. With `MON_PRIO_LOCKED` = 0 this check is skipped.
- R4: Next, at level 1 only, the outcome is trap to hypervisor when `el2_enabled` is 1, either `el3_present` is 0 or `fgt_enable` is 1, and the direction bit is set. The direction bit is `fgt_write_trap` for writes (`req_write` = 1) and `fgt_read_trap` for reads.
- R5: Next, at level 1 only, the outcome is trap to hypervisor when `el2_enabled` and `prof_trap` are both 1.
- R6: Next, at levels 1 and 2, an owner mismatch (as in R3) gives trap to monitor. When `dbg_halted` and `dbg_sec_dis` are both 1, it gives undefined instead.
- R7: If no check fires, the outcome is allow. `rsp_outcome` is one-hot: bit 0 allow, bit 1 undefined, bit 2 trap to hypervisor, bit 3 trap to monitor.
- R8: `rsp_ec` is 8'h18 with either trap outcome and 0 with allow or undefined.
- R9: The result of an accepted request is valid on the next clock edge. `req_ready` equals `!rsp_valid || rsp_ready`. While `rsp_valid` is high and `rsp_ready` is low, the result is held stable.
- R10: After reset `rsp_valid` is 0, and it returns to 0 after the last result is taken if no new request arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_el | input | 2 | Current exception level 0..3 |
| dbg_halted | input | 1 | Core is in halted debug |
| dbg_sec_dis | input | 1 | Secure debug disabled |
| el3_present | input | 1 | Monitor level implemented |
| el2_enabled | input | 1 | Hypervisor level enabled in this state |
| nonsecure | input | 1 | 1 = non-secure state |
| pbuf_owner | input | 2 | Profiling-buffer owner field |
| fgt_enable | input | 1 | Monitor's fine-grained trap enable |
| fgt_read_trap | input | 1 | Fine-grained trap bit for reads |
| fgt_write_trap | input | 1 | Fine-grained trap bit for writes |
| prof_trap | input | 1 | Coarse profiling trap to hypervisor |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Result consumer ready |
| rsp_outcome | output | 4 | One-hot {trap_mon, trap_hyp, undef, allow} |
| rsp_ec | output | 8 | Exception class, nonzero only on traps |

## Verification
Every outcome and exception class is due exactly one clock edge after its request is accepted. The bench drives each request at a falling edge and reads the matching result at the next falling edge, so each vector uses one cycle while `rsp_ready` is high. The sweep covers all 16384 combinations of the request inputs on two instances, one per setting of `MON_PRIO_LOCKED`. A separate back-pressure pass holds `rsp_ready` low for one extra cycle and checks that the first result is unchanged before the second one appears one edge after release.

// File: rtl/sysreg_trap_pkg.sv
package sysreg_trap_pkg;
  localparam int OUT_W     = 4;
  localparam int IDX_ALLOW = 0;
  localparam int IDX_UNDEF = 1;
  localparam int IDX_HYP   = 2;
  localparam int IDX_MON   = 3;

  localparam logic [1:0] OWNER_SECURE    = 2'b01;
  localparam logic [1:0] OWNER_NONSECURE = 2'b11;

  typedef struct packed {
    logic       write;
    logic [1:0] el;
    logic       halted;
    logic       sec_dis;
    logic       el3_on;
    logic       el2_on;
    logic       ns;
    logic [1:0] owner;
    logic       fgt_en;
    logic       fgt_rd;
    logic       fgt_wr;
    logic       prof_trap;
  } acc_req_t;

  function automatic logic [OUT_W-1:0] one_hot(input int idx);
    logic [OUT_W-1:0] v;
    v = '0;
    v[idx] = 1'b1;
    return v;
  endfunction
endpackage

// File: rtl/sysreg_trap_owner.sv
module sysreg_trap_owner
  import sysreg_trap_pkg::*;
(
  input  logic       el3_on,
  input  logic       ns,
  input  logic [1:0] owner,
  output logic       mismatch
);
  logic [1:0] want;
  always_comb begin
    want     = ns ? OWNER_NONSECURE : OWNER_SECURE;
    mismatch = el3_on && (owner != want);
  end
endmodule

// File: rtl/sysreg_trap_prio.sv
module sysreg_trap_prio
  import sysreg_trap_pkg::*;
#(
  parameter bit              MON_PRIO_LOCKED = 1'b1,
  parameter int              EC_W            = 8,
  parameter logic [EC_W-1:0] TRAP_EC         = 8'h18
) (
  input  acc_req_t         req,
  input  logic             owner_bad,
  output logic [OUT_W-1:0] outcome,
  output logic [EC_W-1:0]  ec
);
  logic locked, at_el1, fgt_hit, fgt_live;

  always_comb begin
    locked   = req.halted && req.sec_dis;
    at_el1   = (req.el == 2'd1);
    fgt_live = !req.el3_on || req.fgt_en;
    fgt_hit  = req.write ? req.fgt_wr : req.fgt_rd;

    unique case (req.el)
      2'd0: outcome = one_hot(IDX_UNDEF);
      2'd3: outcome = one_hot(IDX_ALLOW);
      default: begin
        if (MON_PRIO_LOCKED && locked && owner_bad)
          outcome = one_hot(IDX_UNDEF);
        else if (at_el1 && req.el2_on && fgt_live && fgt_hit)
          outcome = one_hot(IDX_HYP);
        else if (at_el1 && req.el2_on && req.prof_trap)
          outcome = one_hot(IDX_HYP);
        else if (owner_bad)
          outcome = locked ? one_hot(IDX_UNDEF) : one_hot(IDX_MON);
        else
          outcome = one_hot(IDX_ALLOW);
      end
    endcase

    ec = (outcome[IDX_HYP] || outcome[IDX_MON]) ? TRAP_EC : '0;
  end
endmodule

// File: rtl/sysreg_trap_stage.sv
module sysreg_trap_stage #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/sysreg_trap_checker.sv
module sysreg_trap_checker
  import sysreg_trap_pkg::*;
#(
  parameter bit              MON_PRIO_LOCKED = 1'b1,
  parameter int              EC_W            = 8,
  parameter logic [EC_W-1:0] TRAP_EC         = 8'h18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_el,
  input  logic             dbg_halted,
  input  logic             dbg_sec_dis,
  input  logic             el3_present,
  input  logic             el2_enabled,
  input  logic             nonsecure,
  input  logic [1:0]       pbuf_owner,
  input  logic             fgt_enable,
  input  logic             fgt_read_trap,
  input  logic             fgt_write_trap,
  input  logic             prof_trap,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [OUT_W-1:0] rsp_outcome,
  output logic [EC_W-1:0]  rsp_ec
);
  localparam int RES_W = OUT_W + EC_W;

  acc_req_t         req;
  logic             owner_bad;
  logic [OUT_W-1:0] outcome;
  logic [EC_W-1:0]  ec;
  logic [RES_W-1:0] res_q;

  always_comb begin
    req.write     = req_write;
    req.el        = req_el;
    req.halted    = dbg_halted;
    req.sec_dis   = dbg_sec_dis;
    req.el3_on    = el3_present;
    req.el2_on    = el2_enabled;
    req.ns        = nonsecure;
    req.owner     = pbuf_owner;
    req.fgt_en    = fgt_enable;
    req.fgt_rd    = fgt_read_trap;
    req.fgt_wr    = fgt_write_trap;
    req.prof_trap = prof_trap;
  end

  sysreg_trap_owner u_owner (
    .el3_on   (req.el3_on),
    .ns       (req.ns),
    .owner    (req.owner),
    .mismatch (owner_bad)
  );

  sysreg_trap_prio #(
    .MON_PRIO_LOCKED (MON_PRIO_LOCKED),
    .EC_W            (EC_W),
    .TRAP_EC         (TRAP_EC)
  ) u_prio (
    .req       (req),
    .owner_bad (owner_bad),
    .outcome   (outcome),
    .ec        (ec)
  );

  sysreg_trap_stage #(.W(RES_W)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_ready  (req_ready),
    .in_data   ({ec, outcome}),
    .out_valid (rsp_valid),
    .out_ready (rsp_ready),
    .out_data  (res_q)
  );

  assign rsp_outcome = res_q[OUT_W-1:0];
  assign rsp_ec      = res_q[RES_W-1:OUT_W];
endmodule

// File: rtl/sysreg_trap_checker_sva.sv
module sysreg_trap_checker_sva #(
  parameter int EC_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic [1:0]      req_el,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [3:0]      rsp_outcome,
  input logic [EC_W-1:0] rsp_ec
);
  logic take;
  assign take = req_valid && req_ready;

  p_el0_undef_r1: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_el == 2'd0 |=> rsp_valid && rsp_outcome == 4'b0010);

  p_el3_allow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take && req_el == 2'd3 |=> rsp_valid && rsp_outcome == 4'b0001);

  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_outcome) == 1);

  p_ec_trap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ((rsp_ec == 8'h18) == (rsp_outcome[2] || rsp_outcome[3])) &&
                  (rsp_ec == 8'h18 || rsp_ec == '0));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_outcome) && $stable(rsp_ec));

  p_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (!rsp_valid || rsp_ready));

  p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> rsp_valid);

  p_drain_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!rsp_valid || rsp_ready) && !req_valid |=> !rsp_valid);
endmodule

bind sysreg_trap_checker sysreg_trap_checker_sva #(.EC_W(EC_W)) u_sva (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_el      (req_el),
  .rsp_valid   (rsp_valid),
  .rsp_ready   (rsp_ready),
  .rsp_outcome (rsp_outcome),
  .rsp_ec      (rsp_ec)
);

// File: tb/sim_sysreg_trap_checker.sv
`timescale 1ns/1ps
module sim_sysreg_trap_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic       req_valid = 1'b0, req_write = 1'b0;
  logic [1:0] req_el = '0, pbuf_owner = '0;
  logic       dbg_halted = 0, dbg_sec_dis = 0, el3_present = 0, el2_enabled = 0;
  logic       nonsecure = 0, fgt_enable = 0, fgt_read_trap = 0, fgt_write_trap = 0;
  logic       prof_trap = 0, rsp_ready = 1'b0;
  logic       rdy0, rdy1, val0, val1;
  logic [3:0] out0, out1;
  logic [7:0] ec0, ec1;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  sysreg_trap_checker #(.MON_PRIO_LOCKED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy0),
    .req_write(req_write), .req_el(req_el), .dbg_halted(dbg_halted),
    .dbg_sec_dis(dbg_sec_dis), .el3_present(el3_present), .el2_enabled(el2_enabled),
    .nonsecure(nonsecure), .pbuf_owner(pbuf_owner), .fgt_enable(fgt_enable),
    .fgt_read_trap(fgt_read_trap), .fgt_write_trap(fgt_write_trap),
    .prof_trap(prof_trap), .rsp_valid(val0), .rsp_ready(rsp_ready),
    .rsp_outcome(out0), .rsp_ec(ec0));

  sysreg_trap_checker #(.MON_PRIO_LOCKED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(rdy1),
    .req_write(req_write), .req_el(req_el), .dbg_halted(dbg_halted),
    .dbg_sec_dis(dbg_sec_dis), .el3_present(el3_present), .el2_enabled(el2_enabled),
    .nonsecure(nonsecure), .pbuf_owner(pbuf_owner), .fgt_enable(fgt_enable),
    .fgt_read_trap(fgt_read_trap), .fgt_write_trap(fgt_write_trap),
    .prof_trap(prof_trap), .rsp_valid(val1), .rsp_ready(rsp_ready),
    .rsp_outcome(out1), .rsp_ec(ec1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [13:0] v);
    req_write      = v[0];
    req_el         = v[2:1];
    dbg_halted     = v[3];
    dbg_sec_dis    = v[4];
    el3_present    = v[5];
    el2_enabled    = v[6];
    nonsecure      = v[7];
    pbuf_owner     = v[9:8];
    fgt_enable     = v[10];
    fgt_read_trap  = v[11];
    fgt_write_trap = v[12];
    prof_trap      = v[13];
  endtask

  // Expected outcome, one-hot {mon, hyp, undef, allow}
  function automatic logic [3:0] model(input logic [13:0] v, input bit prio);
    int  el;
    bit  lock, bad, fg, dirbit;
    el     = int'(v[2:1]);
    lock   = v[3] & v[4];
    bad    = v[5] && (v[7] ? (v[9:8] != 2'd3) : (v[9:8] != 2'd1));
    fg     = !v[5] || v[10];
    dirbit = v[0] ? v[12] : v[11];
    if (el == 0) return 4'b0010;                          // R1
    if (el == 3) return 4'b0001;                          // R2
    if (prio && lock && bad) return 4'b0010;              // R3
    if (el == 1 && v[6] && fg && dirbit) return 4'b0100;  // R4
    if (el == 1 && v[6] && v[13]) return 4'b0100;         // R5
    if (bad) return lock ? 4'b0010 : 4'b1000;             // R6
    return 4'b0001;                                       // R7
  endfunction

  function automatic string tag_of(input logic [13:0] v, input bit prio);
    int  el;
    bit  lock, bad, fg, dirbit;
    el     = int'(v[2:1]);
    lock   = v[3] & v[4];
    bad    = v[5] && (v[7] ? (v[9:8] != 2'd3) : (v[9:8] != 2'd1));
    fg     = !v[5] || v[10];
    dirbit = v[0] ? v[12] : v[11];
    if (el == 0) return "R1";
    if (el == 3) return "R2";
    if (prio && lock && bad) return "R3";
    if (el == 1 && v[6] && fg && dirbit) return "R4";
    if (el == 1 && v[6] && v[13]) return "R5";
    if (bad) return "R6";
    return "R7";
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [3:0] e0, e1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R10 reset valid u0", 32'(val0), 32'd0);
    chk("R10 reset valid u1", 32'(val1), 32'd0);
    chk("R9 ready when empty", 32'(rdy0), 32'd1);

    rsp_ready = 1'b1;
    req_valid = 1'b1;
    for (int v = 0; v < 16384; v++) begin
      drive(14'(v));
      @(negedge clk);
      e0 = model(14'(v), 1'b1);
      e1 = model(14'(v), 1'b0);
      chk("R9 valid", 32'(val0 & val1), 32'd1);
      chk({tag_of(14'(v), 1'b1), " outcome prio=1"}, 32'(out0), 32'(e0));
      chk({tag_of(14'(v), 1'b0), " outcome prio=0"}, 32'(out1), 32'(e1));
      chk("R8 ec prio=1", 32'(ec0), (e0[2] | e0[3]) ? 32'h18 : 32'h0);
      chk("R8 ec prio=0", 32'(ec1), (e1[2] | e1[3]) ? 32'h18 : 32'h0);
    end
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10 drained", 32'(val0 | val1), 32'd0);

    // Back-pressure: A = el1 halted+sdd, el3 present, secure owner 00
    rsp_ready = 1'b0;
    req_valid = 1'b1;
    drive(14'b00_0000_0011_1010);
    @(negedge clk);
    chk("R9 A valid", 32'(val0), 32'd1);
    chk("R3 A prio=1", 32'(out0), 32'b0010);
    chk("R6 A prio=0", 32'(out1), 32'b0010);
    chk("R9 ready low while held", 32'(rdy0), 32'd0);
    // B = el2, el3 present, nonsecure owner 01, not halted -> monitor trap
    drive(14'b00_0001_1010_0100);
    @(negedge clk);
    chk("R9 A held", 32'(out0), 32'b0010);
    chk("R9 A held valid", 32'(val0), 32'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R6 B after release", 32'(out0), 32'b1000);
    chk("R8 B ec", 32'(ec0), 32'h18);
    @(negedge clk);
    chk("R10 empty again", 32'(val0), 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule